// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Passive-Symbol Classifier

This block listens to a single-wire variable-pulse-width serial bus and sorts every passive stretch of the line by its length. The line is first resynchronized and cleaned of single-sample spikes. A timer then starts at each active-to-passive transition, and the passive interval ends at the next passive-to-active transition. The length of that interval selects one result: a data bit of value 0 or 1, an end-of-data mark, an end-of-frame mark, end-of-frame followed by inter-frame separation, or an invalid bit. A passive line that outlasts the longest window is reported as an idle bus without waiting for any edge. Each result leaves the block as a one-cycle strobe together with a 3-bit symbol code.

A transmitter next to the block uses two extra outputs. `tx_permit_o` is high whenever the block has seen end-of-frame or an idle bus, so a pending message may go out. `arb_start_o` pulses on any passive-to-active edge while that permission holds. This lets a waiting node join arbitration at once, even when its own separation timer has not yet expired. The active half of each symbol is not timed here.

The controller is a five-state machine. `ST_IDLE` is the reset state for an idle bus. `ST_ACTIVE` covers the active phase. `ST_PASSIVE` times a passive interval that is still short of end-of-frame. `ST_EOF_WAIT` means end-of-frame has been reached. `ST_IFS_WAIT` means the inter-frame separation window has been reached. The transitions are as follows:
- `ST_IDLE`→`ST_ACTIVE` on a start-of-frame edge.
- `ST_ACTIVE`→`ST_PASSIVE` on an active-to-passive edge.
- `ST_PASSIVE`→`ST_ACTIVE` on an edge, reporting a bit, end-of-data or invalid.
- `ST_PASSIVE`→`ST_EOF_WAIT` when the timer reaches `T_D`.
- `ST_EOF_WAIT`→`ST_ACTIVE` on an edge, reporting end-of-frame.
- `ST_EOF_WAIT`→`ST_IFS_WAIT` when the timer reaches `T_EOF`.
- `ST_IFS_WAIT`→`ST_ACTIVE` on an edge, reporting end-of-frame plus separation.
- `ST_IFS_WAIT`→`ST_IDLE` when the timer reaches `T_IFS`, reporting idle.

Top module: `vpw_rx_classifier`

## Requirements
- R1: While reset is asserted, and right after it is released with a passive line, the block is in the idle-bus condition: `sym_valid_o`=0, `arb_start_o`=0 and `tx_permit_o`=1.
- R2: A passive interval of P clock cycles with P < `T_A` yields code 6 (invalid).
- R3: `T_A` ≤ P < `T_B` yields code 0 (data bit 0).
- R4: `T_B` ≤ P < `T_C` yields code 1 (data bit 1).
- R5: `T_C` ≤ P < `T_D` yields code 2 (end-of-data).
- R6: `T_D` ≤ P < `T_EOF` yields code 3 (end-of-frame) and pulses `arb_start_o` in the same cycle.
- R7: `T_EOF` ≤ P < `T_IFS` yields code 4 (end-of-frame plus separation) and pulses `arb_start_o` in the same cycle.
- R8: A passive line that reaches `T_IFS` cycles with no edge yields exactly one code 5 (idle) strobe. The next passive-to-active edge yields no code, only an `arb_start_o` pulse.
- R9: Each passive interval produces exactly one `sym_valid_o` strobe, one cycle wide, with a code in the range 0..6.
- R10: `tx_permit_o` is high while the passive line has lasted at least `T_D` cycles and while the bus is idle. It is low during an active phase and during a passive interval shorter than `T_D`.
- R11: `arb_start_o` is a one-cycle pulse that occurs only on a passive-to-active edge seen while `tx_permit_o` was high.
- R12: A line pulse lasting a single clock cycle is ignored, and the passive interval around it is timed as one interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the timer counts one step per cycle |
| rst_i | input | 1 | Synchronous reset, active high; returns to idle bus |
| bus_active_i | input | 1 | Raw asynchronous bus level, 1 = active, 0 = passive |
| sym_valid_o | output | 1 | One-cycle strobe marking a new symbol code |
| sym_code_o | output | 3 | 0 bit0, 1 bit1, 2 end-of-data, 3 end-of-frame, 4 end-of-frame + separation, 5 idle, 6 invalid |
| tx_permit_o | output | 1 | End-of-frame or idle seen; a transmitter may start |
| arb_start_o | output | 1 | One-cycle pulse: start transmitting now on this edge |

## Verification
The main stimulus is a set of passive intervals placed one cycle on each side of every window edge. This tells apart an off-by-one error or a wrong comparison at each of the six thresholds. Mid-window lengths separate a wrongly ordered decision chain from a boundary slip. A long interval that is sampled before and after `T_D` shows when the transmit permission comes up. Intervals at and past `T_IFS` separate the idle timeout from an end-of-frame-plus-separation edge. A single-cycle spike inside a data bit shows that the filter hides it and does not split the interval. A reset in the middle of a passive interval shows that the block drops back to idle without emitting a stray symbol.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

    // Symbol codes driven on sym_code_o
    typedef enum logic [2:0] {
        SYM_BIT0    = 3'd0,
        SYM_BIT1    = 3'd1,
        SYM_EOD     = 3'd2,
        SYM_EOF     = 3'd3,
        SYM_EOF_IFS = 3'd4,
        SYM_IDLE    = 3'd5,
        SYM_INVALID = 3'd6
    } vpw_sym_e;

    // Classifier controller states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACTIVE   = 3'd1,
        ST_PASSIVE  = 3'd2,
        ST_EOF_WAIT = 3'd3,
        ST_IFS_WAIT = 3'd4
    } vpw_state_e;

endpackage

// File: rtl/vpw_rx_sync_filter.sv
// Resynchronizes the raw bus level, votes over a short sample window and
// produces single-cycle edge pulses from the cleaned level.
module vpw_rx_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bus_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int VOTE_MIN = VOTE_TAPS / 2 + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   tap_q;
    logic                   level_q;
    logic                   prev_q;
    logic                   vote;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q[g] <= 1'b0;
                else       sync_q[g] <= bus_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q[g] <= 1'b0;
                else       sync_q[g] <= sync_q[g-1];
            end
        end
    end

    for (genvar t = 0; t < VOTE_TAPS; t++) begin : g_tap
        if (t == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) tap_q[t] <= 1'b0;
                else       tap_q[t] <= sync_q[SYNC_STAGES-1];
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) tap_q[t] <= 1'b0;
                else       tap_q[t] <= tap_q[t-1];
            end
        end
    end

    always_comb vote = ($countones(tap_q) >= VOTE_MIN);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            level_q <= vote;
            prev_q  <= level_q;
        end
    end

    always_comb begin
        rise_o = level_q & ~prev_q;
        fall_o = ~level_q & prev_q;
    end

endmodule

// File: rtl/vpw_rx_interval_timer.sv
// Saturating duration counter; a restart loads one so that the value seen
// on the cycle of the closing edge equals the interval length in cycles.
module vpw_rx_interval_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i)                  count_o <= '0;
        else if (restart_i)         count_o <= CNT_ONE;
        else if (count_o != CNT_MAX) count_o <= count_o + CNT_ONE;
    end

endmodule

// File: rtl/vpw_rx_classifier.sv
module vpw_rx_classifier
    import vpw_rx_pkg::*;
#(
    parameter int T_A         = 34,
    parameter int T_B         = 96,
    parameter int T_C         = 163,
    parameter int T_D         = 239,
    parameter int T_EOF       = 280,
    parameter int T_IFS       = 300,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       bus_active_i,
    output logic       sym_valid_o,
    output logic [2:0] sym_code_o,
    output logic       tx_permit_o,
    output logic       arb_start_o
);
    localparam int CNT_W = $clog2(T_IFS + 1) + 1;

    localparam logic [CNT_W-1:0] LIM_A      = CNT_W'(T_A);
    localparam logic [CNT_W-1:0] LIM_B      = CNT_W'(T_B);
    localparam logic [CNT_W-1:0] LIM_C      = CNT_W'(T_C);
    // Leave a state one cycle early so the state matches the count it holds
    localparam logic [CNT_W-1:0] LIM_D_M1   = CNT_W'(T_D - 1);
    localparam logic [CNT_W-1:0] LIM_EOF_M1 = CNT_W'(T_EOF - 1);
    localparam logic [CNT_W-1:0] LIM_IFS_M1 = CNT_W'(T_IFS - 1);

    logic             edge_rise;
    logic             edge_fall;
    logic             restart;
    logic [CNT_W-1:0] elapsed;

    vpw_state_e state_q;
    vpw_state_e state_n;
    vpw_sym_e   code_n;
    logic       valid_n;
    logic       arb_n;

    vpw_rx_sync_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .VOTE_TAPS  (VOTE_TAPS)
    ) u_filter (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .bus_i (bus_active_i),
        .rise_o(edge_rise),
        .fall_o(edge_fall)
    );

    vpw_rx_interval_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .restart_i(restart),
        .count_o  (elapsed)
    );

    // Next-state and symbol decision
    always_comb begin
        state_n = state_q;
        code_n  = SYM_BIT0;
        valid_n = 1'b0;
        arb_n   = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_rise) begin
                    state_n = ST_ACTIVE;
                    arb_n   = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (edge_fall) begin
                    state_n = ST_PASSIVE;
                    restart = 1'b1;
                end
            end
            ST_PASSIVE: begin
                if (edge_rise) begin
                    state_n = ST_ACTIVE;
                    valid_n = 1'b1;
                    if (elapsed < LIM_A)      code_n = SYM_INVALID;
                    else if (elapsed < LIM_B) code_n = SYM_BIT0;
                    else if (elapsed < LIM_C) code_n = SYM_BIT1;
                    else                      code_n = SYM_EOD;
                end else if (elapsed >= LIM_D_M1) begin
                    state_n = ST_EOF_WAIT;
                end
            end
            ST_EOF_WAIT: begin
                if (edge_rise) begin
                    state_n = ST_ACTIVE;
                    valid_n = 1'b1;
                    code_n  = SYM_EOF;
                    arb_n   = 1'b1;
                end else if (elapsed >= LIM_EOF_M1) begin
                    state_n = ST_IFS_WAIT;
                end
            end
            ST_IFS_WAIT: begin
                if (edge_rise) begin
                    state_n = ST_ACTIVE;
                    valid_n = 1'b1;
                    code_n  = SYM_EOF_IFS;
                    arb_n   = 1'b1;
                end else if (elapsed >= LIM_IFS_M1) begin
                    state_n = ST_IDLE;
                    valid_n = 1'b1;
                    code_n  = SYM_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_n;
    end

    // Registered outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sym_valid_o <= 1'b0;
            sym_code_o  <= SYM_IDLE;
            arb_start_o <= 1'b0;
            tx_permit_o <= 1'b1;
        end else begin
            sym_valid_o <= valid_n;
            sym_code_o  <= code_n;
            arb_start_o <= arb_n;
            tx_permit_o <= (state_n == ST_IDLE) || (state_n == ST_EOF_WAIT)
                        || (state_n == ST_IFS_WAIT);
        end
    end

endmodule

// File: rtl/vpw_rx_classifier_checker.sv
module vpw_rx_classifier_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       sym_valid_o,
    input logic [2:0] sym_code_o,
    input logic       tx_permit_o,
    input logic       arb_start_o
);
    // R1: reset leaves the idle-bus condition on the outputs
    p_reset_idle_r1: assert property (@(posedge clk_i)
        rst_i |=> (tx_permit_o && !sym_valid_o && !arb_start_o));

    // R9: strobe is one cycle wide
    p_strobe_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        sym_valid_o |=> !sym_valid_o);

    // R9: code stays within the defined set
    p_code_range_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        sym_valid_o |-> (sym_code_o <= 3'd6));

    // R11: start pulse is one cycle wide
    p_arb_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        arb_start_o |=> !arb_start_o);

    // R11: start pulse only follows a cycle with permission
    p_arb_needs_permit_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        arb_start_o |-> $past(tx_permit_o));

    // R6, R7: a start pulse with a code only comes with the frame-end codes
    p_arb_code_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (arb_start_o && sym_valid_o) |-> (sym_code_o inside {3'd3, 3'd4}));

    // R8: idle report leaves permission up
    p_idle_permit_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (sym_valid_o && sym_code_o == 3'd5) |-> tx_permit_o);

    // R10: short-interval codes end in an active phase without permission
    p_short_no_permit_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (sym_valid_o && (sym_code_o inside {3'd0, 3'd1, 3'd2, 3'd6})) |-> !tx_permit_o);

endmodule

bind vpw_rx_classifier vpw_rx_classifier_checker u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sym_valid_o(sym_valid_o),
    .sym_code_o (sym_code_o),
    .tx_permit_o(tx_permit_o),
    .arb_start_o(arb_start_o)
);

// File: tb/vpw_rx_classifier_bench.sv
`timescale 1ns/1ps
module vpw_rx_classifier_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus = 1'b0;
    logic       sym_valid;
    logic [2:0] sym_code;
    logic       tx_permit;
    logic       arb_start;

    int n_checks = 0;
    int n_fail   = 0;
    int n_sym    = 0;
    int n_arb    = 0;
    int last_code = -1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vpw_rx_classifier u_vpw_rx_classifier (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_active_i(bus),
        .sym_valid_o (sym_valid),
        .sym_code_o  (sym_code),
        .tx_permit_o (tx_permit),
        .arb_start_o (arb_start)
    );

    // Output monitor, away from the rising edge
    always @(negedge clk) begin
        if (!rst && sym_valid) begin
            n_sym++;
            last_code = int'(sym_code);
        end
        if (!rst && arb_start) n_arb++;
    end

    // {passive length, expected code, expected start pulses}
    localparam int VEC_N = 15;
    localparam logic [31:0] VEC [VEC_N] = '{
        {16'd10,  8'd6, 8'd0}, {16'd33,  8'd6, 8'd0},
        {16'd34,  8'd0, 8'd0}, {16'd64,  8'd0, 8'd0},
        {16'd95,  8'd0, 8'd0}, {16'd96,  8'd1, 8'd0},
        {16'd130, 8'd1, 8'd0}, {16'd162, 8'd1, 8'd0},
        {16'd163, 8'd2, 8'd0}, {16'd200, 8'd2, 8'd0},
        {16'd238, 8'd2, 8'd0}, {16'd239, 8'd3, 8'd1},
        {16'd279, 8'd3, 8'd1}, {16'd280, 8'd4, 8'd1},
        {16'd299, 8'd4, 8'd1}
    };

    function automatic string req_of(input int code);
        case (code)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        bus = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int s0;
        int a0;
        repeat (5) @(negedge clk);
        // R1: reset condition while held and right after release
        check("R1 permit in reset", int'(tx_permit), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(sym_valid), 0);
        check("R1 permit after reset", int'(tx_permit), 1);
        check("R1 start after reset", int'(arb_start), 0);

        // R8, R11: start-of-frame from idle gives a start pulse and no code
        s0 = n_sym; a0 = n_arb;
        hold(1'b1, 20);
        check("R11 start from idle", n_arb - a0, 1);
        check("R8 no code on idle edge", n_sym - s0, 0);
        check("R10 permit low while active", int'(tx_permit), 0);

        // Table of window boundaries, one interval per entry
        for (int i = 0; i < VEC_N; i++) begin
            int plen = int'(VEC[i][31:16]);
            int ecode = int'(VEC[i][15:8]);
            int earb = int'(VEC[i][7:0]);
            s0 = n_sym; a0 = n_arb;
            hold(1'b0, plen);
            hold(1'b1, 20);
            check({req_of(ecode), " code"}, last_code, ecode);
            check("R9 one strobe", n_sym - s0, 1);
            check({req_of(ecode), " start pulse"}, n_arb - a0, earb);
        end

        // R10: permission rises only once the passive line passes T_D
        s0 = n_sym;
        hold(1'b0, 200);
        check("R10 permit low before T_D", int'(tx_permit), 0);
        hold(1'b0, 60);
        check("R10 permit high after T_D", int'(tx_permit), 1);
        check("R10 no early strobe", n_sym - s0, 0);
        hold(1'b1, 20);
        check("R6 code after permit", last_code, 3);
        check("R10 permit low after edge", int'(tx_permit), 0);

        // R8: exactly T_IFS without an edge reports idle
        s0 = n_sym; a0 = n_arb;
        hold(1'b0, 300);
        hold(1'b1, 20);
        check("R8 idle code at T_IFS", last_code, 5);
        check("R8 single idle strobe", n_sym - s0, 1);
        check("R8 start on next edge", n_arb - a0, 1);

        // R8: long idle stays quiet after its single report
        s0 = n_sym;
        hold(1'b0, 600);
        check("R8 one strobe over long idle", n_sym - s0, 1);
        check("R10 permit while idle", int'(tx_permit), 1);
        hold(1'b1, 20);
        check("R8 no code on edge after idle", n_sym - s0, 1);

        // R12: single-cycle spikes are filtered out
        s0 = n_sym;
        hold(1'b0, 50);
        hold(1'b1, 1);
        hold(1'b0, 60);
        hold(1'b1, 10);
        hold(1'b0, 1);
        hold(1'b1, 20);
        check("R12 merged interval code", last_code, 1);
        check("R12 single strobe", n_sym - s0, 1);

        // R1: reset during a passive interval returns to idle quietly
        s0 = n_sym;
        hold(1'b0, 150);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 permit after mid reset", int'(tx_permit), 1);
        check("R1 valid after mid reset", int'(sym_valid), 0);
        hold(1'b0, 50);
        check("R1 no strobe after mid reset", n_sym - s0, 0);
        a0 = n_arb;
        hold(1'b1, 20);
        check("R11 start after mid reset", n_arb - a0, 1);
        check("R8 no code after mid reset edge", n_sym - s0, 0);

        done = 1'b1;
        finish_run();
    end

endmodule